// File: doc/BRIEF.md
# Byte-Lane Double-Correcting Memory Codec

This block sits in the data path between a processor's external bus and a bank of static RAM. Each byte lane of the bus is protected on its own. On the write side, every data byte is widened into a 20-bit codeword. The low 8 bits are the byte itself and the upper 12 bits are check bits. The codeword leaves on the memory side combinationally, in the same cycle the byte is presented, so the memory's own write strobe can capture it without any extra latency. On the read side, the codeword returned by the memory is decoded in the cycle of the read strobe. The corrected byte is registered and handed to the processor one cycle later.

The code is a linear block code with minimum distance 8. The syndrome of each lane is matched in parallel against all 20 single-bit and all 190 two-bit error signatures. A match flips the affected data bits back. A non-zero syndrome with no match is classed as an uncorrectable multiple error, and the received data bits are passed on untouched. The most severe class seen across all lanes is latched into a three-bit status at the first faulty read. That status, together with a level interrupt request, is held until the processor pulses an acknowledge.

Top module: `edac_flow`

## Requirements
- R1: For every lane, `mem_wcode` holds a 20-bit codeword per lane (lane n at bits [20n+19:20n]). Its bits [7:0] equal that lane's data byte and its bits [19:8] are the check bits. The codeword follows `cpu_wdata` combinationally, and equal bytes in different lanes give equal codewords.
- R2: The all-zero byte encodes to an all-zero codeword. Encoding is linear, so the codeword of a XOR b equals the XOR of their codewords. Every non-zero byte encodes to a codeword with at least 8 ones.
- R3: A read strobe `rd_en` high at a rising edge makes `rd_valid` high for exactly the following cycle, with `cpu_rdata` carrying the decoded lanes. Without a strobe, `rd_valid` is low and `cpu_rdata` keeps its value.
- R4: Any pattern of 0, 1 or 2 flipped bits within one lane's 20-bit codeword returns that lane's original byte exactly, whatever happens in the other lanes.
- R5: A pattern of 3, 4 or 5 flipped bits in a lane is classed as multiple, and the lane returns its received bits [7:0] unchanged. A 6-bit pattern always gives a non-zero class.
- R6: The status encoding has bit 0 for one corrected bit, bit 1 for two corrected bits and bit 2 for an uncorrectable error; 000 means clean. When lanes differ within one read, the most severe class is reported (multiple over double over single).
- R7: The status is captured on the first faulty read after it was clear. Later reads do not change it while it is held, even if they are worse. `irq` is high exactly while the status is non-zero.
- R8: An `irq_ack` pulse clears the status and `irq` at the next edge. If a read arrives in the same cycle as the pulse, that read's class is captured instead of being lost.
- R9: While `rst` is high at an edge, `rd_valid`, `cpu_rdata`, `err_status` and `irq` are driven to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for both paths |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wdata | input | LANES*8 | Write data from the processor |
| mem_wcode | output | LANES*20 | Encoded codewords to memory, combinational |
| rd_en | input | 1 | Read strobe; memory presents `mem_rcode` in the same cycle |
| mem_rcode | input | LANES*20 | Codewords read back from memory |
| cpu_rdata | output | LANES*8 | Corrected read data, registered |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| irq_ack | input | 1 | Acknowledge pulse that clears the held status |
| err_status | output | 3 | Latched error class (one-hot or zero) |
| irq | output | 1 | Level interrupt request, high while status is non-zero |

## Verification
The acknowledge that clears a held error and a new faulty read can land on the same clock edge. The bench provokes this deliberately: nearly every read in the exhaustive sweep is issued together with `irq_ack`, and a dedicated case holds a single-bit error and then issues a double-bit read alongside the acknowledge. The cycle model expects the new read's class to appear, never a cleared status. The converse case is also run: an acknowledge with no read must clear the status, while faulty reads without acknowledge must leave the first captured class in place.

// File: rtl/edac_pkg.sv
`timescale 1ns/1ps
package edac_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 12;
  localparam int CW_W   = DATA_W + CHK_W;
  localparam int PAIRS  = CW_W * (CW_W - 1) / 2;

  // error class codes, bit 0 = one flip, bit 1 = two flips, bit 2 = uncorrectable
  localparam logic [2:0] SEV_NONE  = 3'b000;
  localparam logic [2:0] SEV_ONE   = 3'b001;
  localparam logic [2:0] SEV_TWO   = 3'b010;
  localparam logic [2:0] SEV_MULTI = 3'b100;

  // seed of the cyclic part of the check matrix (distance-8 family, shortened)
  localparam logic [10:0] ROT_SEED = 11'b11011100010;

  function automatic logic [CHK_W-1:0] data_col(input int idx);
    logic [10:0] r;
    r = ROT_SEED;
    for (int k = 0; k < idx; k++) r = {r[9:0], r[10]};
    return {r, 1'b1};
  endfunction

  // syndrome produced by a single flip at codeword position pos
  function automatic logic [CHK_W-1:0] syn_col(input int pos);
    logic [CHK_W-1:0] c;
    c = '0;
    if (pos < DATA_W) c = data_col(pos);
    else              c[pos-DATA_W] = 1'b1;
    return c;
  endfunction

  function automatic logic [CHK_W-1:0] calc_chk(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < DATA_W; i++)
      if (d[i]) acc = acc ^ data_col(i);
    return acc;
  endfunction

  function automatic logic [2:0] sev_max(input logic [2:0] a, input logic [2:0] b);
    logic [2:0] u;
    u = a | b;
    if (u[2])      return SEV_MULTI;
    else if (u[1]) return SEV_TWO;
    else if (u[0]) return SEV_ONE;
    return SEV_NONE;
  endfunction
endpackage

// File: rtl/edac_byte_enc.sv
`timescale 1ns/1ps
module edac_byte_enc
  import edac_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   code_o
);
  always_comb code_o = {calc_chk(data_i), data_i};
endmodule

// File: rtl/edac_byte_dec.sv
`timescale 1ns/1ps
module edac_byte_dec
  import edac_pkg::*;
(
  input  logic [CW_W-1:0]   code_i,
  output logic [DATA_W-1:0] data_o,
  output logic [2:0]        sev_o
);
  logic [CHK_W-1:0]  syn;
  logic [DATA_W-1:0] flip;
  logic              hit_one;
  logic              hit_two;

  always_comb begin
    syn     = code_i[CW_W-1:DATA_W] ^ calc_chk(code_i[DATA_W-1:0]);
    flip    = '0;
    hit_one = 1'b0;
    hit_two = 1'b0;
    for (int p = 0; p < CW_W; p++) begin
      if (syn == syn_col(p)) begin
        hit_one = 1'b1;
        if (p < DATA_W) flip[p] = 1'b1;
      end
    end
    for (int p = 0; p < CW_W; p++) begin
      for (int q = p + 1; q < CW_W; q++) begin
        if (syn == (syn_col(p) ^ syn_col(q))) begin
          hit_two = 1'b1;
          if (p < DATA_W) flip[p] = 1'b1;
          if (q < DATA_W) flip[q] = 1'b1;
        end
      end
    end
    data_o = code_i[DATA_W-1:0] ^ flip;
    if (syn == '0)   sev_o = SEV_NONE;
    else if (hit_one) sev_o = SEV_ONE;
    else if (hit_two) sev_o = SEV_TWO;
    else              sev_o = SEV_MULTI;
  end
endmodule

// File: rtl/edac_err_latch.sv
`timescale 1ns/1ps
module edac_err_latch
  import edac_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       capture,
  input  logic       ack,
  input  logic [2:0] sev,
  output logic [2:0] status,
  output logic       irq
);
  logic [2:0] nxt;

  always_comb begin
    nxt = status;
    if (ack)
      nxt = capture ? sev : SEV_NONE;
    else if (capture && status == SEV_NONE)
      nxt = sev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= SEV_NONE;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |nxt;
    end
  end
endmodule

// File: rtl/edac_flow.sv
`timescale 1ns/1ps
module edac_flow
  import edac_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [LANES*8-1:0]    cpu_wdata,
  output logic [LANES*20-1:0]   mem_wcode,
  input  logic                  rd_en,
  input  logic [LANES*20-1:0]   mem_rcode,
  output logic [LANES*8-1:0]    cpu_rdata,
  output logic                  rd_valid,
  input  logic                  irq_ack,
  output logic [2:0]            err_status,
  output logic                  irq
);
  localparam int BUS_W  = LANES * DATA_W;
  localparam int CODE_W = LANES * CW_W;

  logic [BUS_W-1:0] fixed_data;
  logic [2:0]       lane_sev [LANES];
  logic [2:0]       worst_sev;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edac_byte_enc u_enc (
      .data_i (cpu_wdata[g*DATA_W +: DATA_W]),
      .code_o (mem_wcode[g*CW_W +: CW_W])
    );
    edac_byte_dec u_dec (
      .code_i (mem_rcode[g*CW_W +: CW_W]),
      .data_o (fixed_data[g*DATA_W +: DATA_W]),
      .sev_o  (lane_sev[g])
    );
  end

  always_comb begin
    worst_sev = SEV_NONE;
    for (int l = 0; l < LANES; l++) worst_sev = sev_max(worst_sev, lane_sev[l]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) cpu_rdata <= fixed_data;
    end
  end

  edac_err_latch u_latch (
    .clk     (clk),
    .rst     (rst),
    .capture (rd_en),
    .ack     (irq_ack),
    .sev     (worst_sev),
    .status  (err_status),
    .irq     (irq)
  );

  logic [CODE_W-1:0] unused_width_ref;
  assign unused_width_ref = '0;
endmodule

// File: rtl/edac_flow_chk.sv
`timescale 1ns/1ps
module edac_flow_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic             irq_ack,
  input logic             rd_valid,
  input logic [BUS_W-1:0] cpu_rdata,
  input logic [2:0]       err_status,
  input logic             irq
);
  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid); // R3
  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid); // R3
  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(cpu_rdata)); // R3
  AST_STATUS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(err_status)); // R6
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == (err_status != 3'b000)); // R7
  AST_STATUS_HELD: assert property (@(posedge clk) disable iff (rst)
    (err_status != 3'b000 && !irq_ack) |=> $stable(err_status)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !rd_en) |=> (err_status == 3'b000 && !irq)); // R8
endmodule

bind edac_flow edac_flow_chk #(.BUS_W(BUS_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rd_en      (rd_en),
  .irq_ack    (irq_ack),
  .rd_valid   (rd_valid),
  .cpu_rdata  (cpu_rdata),
  .err_status (err_status),
  .irq        (irq)
);

// File: tb/tb_edac_flow.sv
`timescale 1ns/1ps
module tb_edac_flow;
  localparam int LANES  = 4;
  localparam int CWW    = 20;
  localparam int BUS_W  = LANES * 8;
  localparam int CODE_W = LANES * CWW;
  localparam logic [2:0] S_NONE = 3'b000, S_ONE = 3'b001, S_TWO = 3'b010, S_MULTI = 3'b100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BUS_W-1:0]  cpu_wdata = '0;
  logic [CODE_W-1:0] mem_wcode;
  logic rd_en = 1'b0;
  logic [CODE_W-1:0] mem_rcode = '0;
  logic [BUS_W-1:0]  cpu_rdata;
  logic rd_valid;
  logic irq_ack = 1'b0;
  logic [2:0] err_status;
  logic irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [CWW-1:0]   enc_tab [256];
  logic [2:0]       m_stat  = S_NONE;
  logic [BUS_W-1:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  edac_flow #(.LANES(LANES)) dut (
    .clk(clk), .rst(rst), .cpu_wdata(cpu_wdata), .mem_wcode(mem_wcode),
    .rd_en(rd_en), .mem_rcode(mem_rcode), .cpu_rdata(cpu_rdata),
    .rd_valid(rd_valid), .irq_ack(irq_ack), .err_status(err_status), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] class_of(input int w);
    if (w == 0) return S_NONE;
    if (w == 1) return S_ONE;
    if (w == 2) return S_TWO;
    return S_MULTI;
  endfunction

  function automatic logic [2:0] worst(input logic [2:0] a, input logic [2:0] b);
    if (a == S_MULTI || b == S_MULTI) return S_MULTI;
    if (a == S_TWO || b == S_TWO) return S_TWO;
    if (a == S_ONE || b == S_ONE) return S_ONE;
    return S_NONE;
  endfunction

  function automatic logic [CWW-1:0] rand_mask(input int w);
    logic [CWW-1:0] m;
    m = '0;
    while ($countones(m) < w) m[$urandom_range(CWW-1)] = 1'b1;
    return m;
  endfunction

  // one read cycle, compared against the cycle model afterwards
  task automatic do_read(input logic [CODE_W-1:0] code, input bit ack,
                         input logic [BUS_W-1:0] exp_data, input logic [2:0] exp_sev,
                         input bit any_sev, input string req);
    bit took;
    rd_en = 1'b1; mem_rcode = code; irq_ack = ack;
    @(negedge clk);
    rd_en = 1'b0; irq_ack = 1'b0;
    took = ack || (m_stat == S_NONE);
    chk(rd_valid === 1'b1, "R3 valid", rd_valid, 1);
    if (any_sev) begin
      if (took) begin
        chk(err_status != S_NONE && $onehot(err_status), req, err_status, 0);
        m_stat = err_status;
      end else
        chk(err_status === m_stat, "R7", err_status, m_stat);
      m_rdata = cpu_rdata;
    end else begin
      if (took) m_stat = exp_sev;
      chk(cpu_rdata === exp_data, req, cpu_rdata, exp_data);
      chk(err_status === m_stat, req, err_status, m_stat);
      m_rdata = exp_data;
    end
    chk(irq === (m_stat != S_NONE), "R7 irq", irq, m_stat != S_NONE);
  endtask

  task automatic do_idle(input bit ack, input string req);
    irq_ack = ack;
    @(negedge clk);
    irq_ack = 1'b0;
    if (ack) m_stat = S_NONE;
    chk(rd_valid === 1'b0, "R3 idle valid", rd_valid, 0);
    chk(cpu_rdata === m_rdata, "R3 idle hold", cpu_rdata, m_rdata);
    chk(err_status === m_stat, req, err_status, m_stat);
    chk(irq === (m_stat != S_NONE), req, irq, m_stat != S_NONE);
  endtask

  // random clean bytes in all lanes, one lane corrupted by mask
  task automatic run_pattern(input int lane, input logic [CWW-1:0] mask, input bit ack, input string req);
    logic [BUS_W-1:0]  bytes;
    logic [BUS_W-1:0]  expd;
    logic [CODE_W-1:0] code;
    int w;
    w = $countones(mask);
    for (int l = 0; l < LANES; l++) begin
      bytes[l*8 +: 8] = 8'($urandom_range(255));
      code[l*CWW +: CWW] = enc_tab[bytes[l*8 +: 8]];
    end
    code[lane*CWW +: CWW] = code[lane*CWW +: CWW] ^ mask;
    expd = bytes;
    if (w >= 3) expd[lane*8 +: 8] = code[lane*CWW +: 8];
    do_read(code, ack, expd, class_of(w), w >= 6, req);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [CWW-1:0] cw;
    logic [BUS_W-1:0] bytes;
    logic [CODE_W-1:0] code;
    logic [BUS_W-1:0] expd;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(rd_valid === 1'b0 && cpu_rdata === '0, "R9 data", {rd_valid, cpu_rdata}, 0);
    chk(err_status === 3'b000 && irq === 1'b0, "R9 status", {irq, err_status}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1, R2: encoder table through the write path
    for (int v = 0; v < 256; v++) begin
      cpu_wdata = {LANES{8'(v)}};
      #1;
      cw = mem_wcode[CWW-1:0];
      enc_tab[v] = cw;
      chk(cw[7:0] === 8'(v), "R1 layout", cw[7:0], v);
      for (int l = 1; l < LANES; l++)
        chk(mem_wcode[l*CWW +: CWW] === cw, "R1 lanes", mem_wcode[l*CWW +: CWW], cw);
      if (v == 0) chk(cw === '0, "R2 zero", cw, 0);
      else chk($countones(cw) >= 8, "R2 weight", $countones(cw), 8);
      @(negedge clk);
    end
    for (int a = 0; a < 256; a++) begin
      int b;
      b = (a * 37 + 11) % 256;
      chk(enc_tab[a ^ b] === (enc_tab[a] ^ enc_tab[b]), "R2 linear", enc_tab[a ^ b], enc_tab[a] ^ enc_tab[b]);
    end

    // R4: every 0-, 1-, 2-flip pattern in every lane, ack with each read (R8 same cycle)
    for (int l = 0; l < LANES; l++) begin
      run_pattern(l, '0, 1'b1, "R4 clean");
      for (int p = 0; p < CWW; p++) begin
        run_pattern(l, CWW'(1) << p, 1'b1, "R4 single");
        for (int q = p + 1; q < CWW; q++)
          run_pattern(l, (CWW'(1) << p) | (CWW'(1) << q), 1'b1, "R4 double");
      end
    end

    // R5: heavier patterns
    for (int n = 0; n < 240; n++) run_pattern(n % LANES, rand_mask(3 + n % 3), 1'b1, "R5 multi");
    for (int n = 0; n < 60; n++)  run_pattern(n % LANES, rand_mask(6), 1'b1, "R5 six");
    do_idle(1'b1, "R8 clear");

    // R6: most severe class across lanes
    for (int l = 0; l < LANES; l++) begin
      bytes[l*8 +: 8] = 8'(8'h5a + 8'(l * 29));
      code[l*CWW +: CWW] = enc_tab[bytes[l*8 +: 8]];
    end
    code[3] = ~code[3];
    code[CWW + 0]  = ~code[CWW + 0];
    code[CWW + 12] = ~code[CWW + 12];
    do_read(code, 1'b1, bytes, S_TWO, 1'b0, "R6 worst double");
    code[2*CWW + 1]  = ~code[2*CWW + 1];
    code[2*CWW + 9]  = ~code[2*CWW + 9];
    code[2*CWW + 15] = ~code[2*CWW + 15];
    expd = bytes;
    expd[16 +: 8] = code[2*CWW +: 8];
    do_read(code, 1'b1, expd, S_MULTI, 1'b0, "R6 worst multi");

    // R7: first error held, later errors ignored until ack
    do_idle(1'b1, "R8 idle ack");
    run_pattern(1, '0, 1'b0, "R7 clean");
    run_pattern(2, CWW'(1) << 17, 1'b0, "R7 first");
    run_pattern(0, rand_mask(4), 1'b0, "R7 ignore multi");
    run_pattern(3, rand_mask(2), 1'b0, "R7 ignore double");
    do_idle(1'b0, "R7 hold idle");
    // R8: ack together with a new faulty read captures the new class
    run_pattern(1, rand_mask(2), 1'b1, "R8 same cycle");
    chk(err_status === S_TWO, "R8 new class", err_status, S_TWO);
    do_idle(1'b1, "R8 ack clears");
    run_pattern(0, rand_mask(1), 1'b0, "R7 after clear");
    chk(err_status === S_ONE, "R7 recapture", err_status, S_ONE);
    do_idle(1'b1, "R8 final clear");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule